// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with a small register file on a simple single-cycle write bus and a combinational read port. Software programs a timeout length, enables the timer and must keep writing a restart code before the count runs out. If it does not, the block raises a reset pulse on a pin with selectable polarity or, in interrupt mode, raises an interrupt line instead. A separate register lets software force a reset pulse at once.

Every register that accepts writes checks a key value carried in the write data. A write whose key does not match leaves all state unchanged. The timer counts a slow tick that arrives as a single-cycle enable in the bus clock domain. A divide-by-512 prescaler turns that tick into timeout counts, so one count is 15.625 ms at a 32.768 kHz tick rate. The largest 10-bit length gives just under 16 s.

Top module: `wdog_keyed`

## Requirements
- R1: A write to byte address 0x00 updates the control register only when data bits 31:24 equal 0x22. The fields are bit 0 run, bit 1 polarity, bit 2 reset-pin enable, bit 3 interrupt mode and bit 6 dual flag, which is only stored. Reading 0x00 returns these bits in the same positions and zero elsewhere.
- R2: A write to 0x04 updates the length only when data bits 4:0 equal 5'b01000. The length is taken from bits 14:5. Reading 0x04 returns the length in bits 14:5. After reset the length is 1023.
- R3: A write with a wrong key changes no register, no status bit and no output, and it does not restart the countdown.
- R4: While running, the timer expires after exactly length×512 tick pulses. On expiry it reloads the length and continues. A stored length of 0 acts as 1.
- R5: Writing exactly 0x00001971 to 0x08 reloads the count from the length and clears the prescaler.
- R6: Reading 0x10 returns the current count in bits 9:0.
- R7: On expiry with interrupt mode off, an internal reset pulse is active for exactly 16 clock cycles, starting in the cycle after the expiry edge. The pin is rst_o = (pulse AND reset-pin enable) XOR polarity, so polarity 1 makes the pin active-low.
- R8: On expiry with interrupt mode on, no reset pulse is started. The interrupt output equals the timeout status bit ANDed with interrupt mode.
- R9: Writing exactly 0x00001209 to 0x14 starts the 16-cycle reset pulse at the write edge, whether the timer runs or not and whatever the count is.
- R10: Reading 0x0C gives bit 31 = timeout seen and bit 30 = software reset seen. Both bits are cleared by a correctly keyed write to 0x00. Writes to 0x0C are ignored.
- R11: While not running, the prescaler is held at zero, the count is held at the length and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle slow tick enable |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 5 | Byte address |
| bus_wdata_i | input | 32 | Write data including key |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| rst_o | output | 1 | Reset pin, polarity per control bit 1 |
| irq_o | output | 1 | Timeout interrupt level |

## Verification
A register write takes effect at its own clock edge, so readback, status and the software reset pulse are sampled on the falling edge just after that edge. With a tick in every cycle, the expiry lands exactly length×512 edges after the enabling write. The bench checks one cycle before that edge for no expiry and at that edge for expiry, which pins the count to the cycle. The reset pin is checked at its 16th active cycle and again one cycle later. The bench counts cycles from the write edge and samples only at those points. With a tick every other cycle, the phase is uncertain, so the bench checks a window around the expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Register byte offsets
    localparam logic [4:0] OFS_CTRL    = 5'h00;
    localparam logic [4:0] OFS_LENGTH  = 5'h04;
    localparam logic [4:0] OFS_KICK    = 5'h08;
    localparam logic [4:0] OFS_STATUS  = 5'h0C;
    localparam logic [4:0] OFS_COUNT   = 5'h10;
    localparam logic [4:0] OFS_FORCE   = 5'h14;

    // Key values carried inside the write data
    localparam logic [7:0]  KEY_CTRL   = 8'h22;
    localparam logic [4:0]  KEY_LENGTH = 5'h08;
    localparam logic [31:0] KEY_KICK   = 32'h0000_1971;
    localparam logic [31:0] KEY_FORCE  = 32'h0000_1209;

    // Status bit positions
    localparam int unsigned ST_TMO_BIT = 31;
    localparam int unsigned ST_SW_BIT  = 30;

    typedef struct packed {
        logic dual;
        logic irq_mode;
        logic pin_en;
        logic pol;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we_i,
    input  logic [4:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    input  logic             expire_i,
    input  logic [LEN_W-1:0] cnt_i,
    output logic             run_o,
    output logic             pol_o,
    output logic             pin_en_o,
    output logic             irq_mode_o,
    output logic             tmo_flag_o,
    output logic [LEN_W-1:0] len_eff_o,
    output logic             kick_o,
    output logic             force_o
);

    localparam int unsigned LEN_LSB = 5;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [LEN_W-1:0] len;
        logic             st_tmo;
        logic             st_sw;
    } regs_t;

    regs_t regs_d, regs_q;

    logic ctrl_hit, ctrl_ok, len_hit, len_ok;

    assign ctrl_hit = bus_we_i && (bus_addr_i == OFS_CTRL);
    assign ctrl_ok  = ctrl_hit && (bus_wdata_i[31:24] == KEY_CTRL);
    assign len_hit  = bus_we_i && (bus_addr_i == OFS_LENGTH);
    assign len_ok   = len_hit && (bus_wdata_i[4:0] == KEY_LENGTH);
    assign kick_o   = bus_we_i && (bus_addr_i == OFS_KICK) && (bus_wdata_i == KEY_KICK);
    assign force_o  = bus_we_i && (bus_addr_i == OFS_FORCE) && (bus_wdata_i == KEY_FORCE);

    always_comb begin
        regs_d = regs_q;
        if (ctrl_ok) begin
            regs_d.ctrl.run      = bus_wdata_i[0];
            regs_d.ctrl.pol      = bus_wdata_i[1];
            regs_d.ctrl.pin_en   = bus_wdata_i[2];
            regs_d.ctrl.irq_mode = bus_wdata_i[3];
            regs_d.ctrl.dual     = bus_wdata_i[6];
            regs_d.st_tmo        = 1'b0;
            regs_d.st_sw         = 1'b0;
        end
        if (len_ok) begin
            regs_d.len = bus_wdata_i[LEN_LSB +: LEN_W];
        end
        if (expire_i) begin
            regs_d.st_tmo = 1'b1;
        end
        if (force_o) begin
            regs_d.st_sw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl   <= '0;
            regs_q.len    <= '1;
            regs_q.st_tmo <= 1'b0;
            regs_q.st_sw  <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_CTRL: begin
                bus_rdata_o[0] = regs_q.ctrl.run;
                bus_rdata_o[1] = regs_q.ctrl.pol;
                bus_rdata_o[2] = regs_q.ctrl.pin_en;
                bus_rdata_o[3] = regs_q.ctrl.irq_mode;
                bus_rdata_o[6] = regs_q.ctrl.dual;
            end
            OFS_LENGTH: bus_rdata_o[LEN_LSB +: LEN_W] = regs_q.len;
            OFS_STATUS: begin
                bus_rdata_o[ST_TMO_BIT] = regs_q.st_tmo;
                bus_rdata_o[ST_SW_BIT]  = regs_q.st_sw;
            end
            OFS_COUNT: bus_rdata_o[LEN_W-1:0] = cnt_i;
            default: bus_rdata_o = '0;
        endcase
    end

    assign run_o      = regs_q.ctrl.run;
    assign pol_o      = regs_q.ctrl.pol;
    assign pin_en_o   = regs_q.ctrl.pin_en;
    assign irq_mode_o = regs_q.ctrl.irq_mode;
    assign tmo_flag_o = regs_q.st_tmo;
    assign len_eff_o  = (regs_q.len == '0) ? LEN_W'(1) : regs_q.len;

    // R3
    ctrl_badkey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && !ctrl_ok) |=> $stable(regs_q.ctrl));

    // R2
    len_badkey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_hit && !len_ok) |=> $stable(regs_q.len));

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_ok && !expire_i && !force_o) |=> (!regs_q.st_tmo && !regs_q.st_sw));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned LEN_W    = 10,
    parameter int unsigned PRESCALE = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             kick_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic             expire_o
);

    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [LEN_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic wrap;

    assign wrap     = run_i && tick_i && (st_q.pre == PRE_LAST);
    assign expire_o = wrap && !kick_i && (st_q.cnt == LEN_W'(1));

    always_comb begin
        st_d = st_q;
        if (!run_i || kick_i) begin
            st_d.pre = '0;
            st_d.cnt = len_i;
        end else if (tick_i) begin
            if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                st_d.cnt = (st_q.cnt == LEN_W'(1)) ? len_i : st_q.cnt - LEN_W'(1);
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pre <= '0;
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R5
    kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (st_q.pre == '0 && st_q.cnt == $past(len_i)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.pre == '0));

    // R4
    expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (st_q.cnt == $past(len_i)));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic active_o
);

    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (trig_i) begin
            p_d.left = PW'(PULSE_LEN);
        end else if (p_q.left != '0) begin
            p_d.left = p_q.left - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign active_o = (p_q.left != '0);

    // R9
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (active_o && p_q.left == PW'(PULSE_LEN)));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
    parameter int unsigned LEN_W     = 10,
    parameter int unsigned PRESCALE  = 512,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        bus_we_i,
    input  logic [4:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        rst_o,
    output logic        irq_o
);

    logic             run, pol, pin_en, irq_mode, tmo_flag;
    logic             kick, force_rst, expire, pulse_trig, pulse_on;
    logic [LEN_W-1:0] len_eff, cnt;

    wdog_regs #(.LEN_W(LEN_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .expire_i    (expire),
        .cnt_i       (cnt),
        .run_o       (run),
        .pol_o       (pol),
        .pin_en_o    (pin_en),
        .irq_mode_o  (irq_mode),
        .tmo_flag_o  (tmo_flag),
        .len_eff_o   (len_eff),
        .kick_o      (kick),
        .force_o     (force_rst)
    );

    wdog_counter #(.LEN_W(LEN_W), .PRESCALE(PRESCALE)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .run_i    (run),
        .kick_i   (kick),
        .len_i    (len_eff),
        .cnt_o    (cnt),
        .expire_o (expire)
    );

    assign pulse_trig = force_rst || (expire && !irq_mode);

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (pulse_trig),
        .active_o (pulse_on)
    );

    assign rst_o = (pulse_on && pin_en) ^ pol;
    assign irq_o = tmo_flag && irq_mode;

    // R8
    irq_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_mode && !force_rst && !pulse_on) |=> !pulse_on);

    // R8
    irq_follows_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_mode && !bus_we_i) |=> irq_o);

endmodule

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        slow = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_pin, irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) tick <= slow ? ~tick : 1'b1;

    wdog_keyed i_wdog_keyed (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .rst_o(rst_pin), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); chk("R1 reset ctrl", v, 32'h0);
        rd(5'h04, v); chk("R2 reset length", v, 32'h0000_7FE0);
        rd(5'h0C, v); chk("R10 reset status", v, 32'h0);
        rd(5'h10, v); chk("R6 reset count", v, 32'd1023);
        chk("R7 reset pin", {31'b0, rst_pin}, 32'h0);
        chk("R8 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_key;
        logic [31:0] v;
        wr(5'h00, 32'h2100_0047);
        rd(5'h00, v); chk("R3 ctrl wrong key", v, 32'h0);
        wr(5'h00, 32'h2200_0047);
        rd(5'h00, v); chk("R1 ctrl fields", v, 32'h0000_0047);
        chk("R7 idle pin with polarity 1", {31'b0, rst_pin}, 32'h1);
        wr(5'h00, 32'h2200_0000);
        rd(5'h00, v); chk("R1 ctrl cleared", v, 32'h0);
    endtask

    task automatic t_length;
        logic [31:0] v;
        wr(5'h04, 32'h0000_00A8);
        rd(5'h04, v); chk("R2 length write", v, 32'h0000_00A0);
        wr(5'h04, 32'h0000_00E9);
        rd(5'h04, v); chk("R3 length wrong key", v, 32'h0000_00A0);
        step(1);
        rd(5'h10, v); chk("R11 idle count equals length", v, 32'd5);
    endtask

    task automatic t_expire;
        logic [31:0] v;
        wr(5'h04, 32'h0000_0048);
        wr(5'h00, 32'h2200_0005);
        step(512);
        rd(5'h10, v); chk("R6 count after one prescale period", v, 32'd1);
        step(511);
        rd(5'h0C, v); chk("R4 no expiry one cycle early", v, 32'h0);
        chk("R7 pin idle before expiry", {31'b0, rst_pin}, 32'h0);
        step(1);
        rd(5'h0C, v); chk("R4 expiry after length*512", v, 32'h8000_0000);
        chk("R7 pin active after expiry", {31'b0, rst_pin}, 32'h1);
        rd(5'h10, v); chk("R4 count reloaded", v, 32'd2);
        step(15);
        chk("R7 pin active in 16th cycle", {31'b0, rst_pin}, 32'h1);
        step(1);
        chk("R7 pin released after 16", {31'b0, rst_pin}, 32'h0);
        wr(5'h00, 32'h2200_0000);
        rd(5'h0C, v); chk("R10 keyed ctrl write clears status", v, 32'h0);
    endtask

    task automatic t_kick;
        logic [31:0] v;
        wr(5'h04, 32'h0000_0028);
        wr(5'h00, 32'h2200_0005);
        step(200);
        wr(5'h08, 32'h0000_1970);
        step(310);
        rd(5'h0C, v); chk("R3 wrong restart key early", v, 32'h0);
        step(1);
        rd(5'h0C, v); chk("R3 wrong restart key no reload", v, 32'h8000_0000);
        wr(5'h00, 32'h2200_0000);
        wr(5'h00, 32'h2200_0005);
        step(300);
        wr(5'h08, 32'h0000_1971);
        step(511);
        rd(5'h0C, v); chk("R5 restart postpones expiry", v, 32'h0);
        step(1);
        rd(5'h0C, v); chk("R5 expiry 512 after restart", v, 32'h8000_0000);
        wr(5'h00, 32'h2200_0000);
        step(20);
    endtask

    task automatic t_irq_zero_len;
        logic [31:0] v;
        wr(5'h04, 32'h0000_0008);
        step(1);
        rd(5'h10, v); chk("R4 zero length acts as one", v, 32'd1);
        wr(5'h00, 32'h2200_000D);
        step(511);
        rd(5'h0C, v); chk("R4 zero length no early expiry", v, 32'h0);
        step(1);
        rd(5'h0C, v); chk("R4 zero length expiry at 512", v, 32'h8000_0000);
        chk("R8 irq raised", {31'b0, irq}, 32'h1);
        chk("R8 no reset pulse in irq mode", {31'b0, rst_pin}, 32'h0);
        wr(5'h0C, 32'h0000_0000);
        rd(5'h0C, v); chk("R10 status write ignored", v, 32'h8000_0000);
        step(10);
        chk("R8 pin stays idle", {31'b0, rst_pin}, 32'h0);
        wr(5'h00, 32'h2200_0000);
        chk("R8 irq cleared with status", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_force;
        logic [31:0] v;
        wr(5'h00, 32'h2200_0006);
        chk("R7 active-low idle level", {31'b0, rst_pin}, 32'h1);
        wr(5'h14, 32'h0000_1208);
        rd(5'h0C, v); chk("R3 wrong force key status", v, 32'h0);
        chk("R3 wrong force key pin", {31'b0, rst_pin}, 32'h1);
        wr(5'h14, 32'h0000_1209);
        rd(5'h0C, v); chk("R9 force sets status", v, 32'h4000_0000);
        chk("R9 force pulse immediate", {31'b0, rst_pin}, 32'h0);
        step(15);
        chk("R9 force pulse 16th cycle", {31'b0, rst_pin}, 32'h0);
        step(1);
        chk("R9 force pulse ends", {31'b0, rst_pin}, 32'h1);
        wr(5'h00, 32'h2200_0000);
    endtask

    task automatic t_stop_slow;
        logic [31:0] v;
        slow = 1'b1;
        wr(5'h04, 32'h0000_0028);
        wr(5'h00, 32'h2200_0001);
        step(300);
        wr(5'h00, 32'h2200_0000);
        step(1500);
        rd(5'h0C, v); chk("R11 stopped timer never expires", v, 32'h0);
        rd(5'h10, v); chk("R11 stopped count held at length", v, 32'd1);
        wr(5'h00, 32'h2200_0001);
        step(1000);
        rd(5'h0C, v); chk("R4 sparse ticks no early expiry", v, 32'h0);
        step(40);
        rd(5'h0C, v); chk("R4 sparse ticks expiry", v, 32'h8000_0000);
        wr(5'h00, 32'h2200_0000);
        slow = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_ctrl_key();
        t_length();
        t_expire();
        t_kick();
        t_irq_zero_len();
        t_force();
        t_stop_slow();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule